// File: doc/BRIEF.md
# ATA Device Task-File Register Controller

This block is the device end of an ATA-style disk interface. A host reaches it over a small register bus with two chip selects: one for the eight-entry command block and one for the control block. The block keeps the task-file bytes and builds the status byte. It handles drive selection, software reset and interrupt masking. It runs the protocol for non-data, PIO-in, PIO-out and DMA commands, and it drives an interrupt request line.

Data moves between the host and the sector buffer through the data register. The block gives the buffer a byte offset within the current data block, so byte and 16-bit accesses can be mixed freely. A simple level/pulse pair asks the media side to fill the buffer or to commit it, and it carries the 28-bit block address. A second pair hands DMA commands to an external engine and takes back the end or abort of the transfer.

Top module: `ata_taskfile_dev`

## Requirements
- R1: After reset, with device 0 selected, the status byte reads 0x50. Sector count and sector number read 0x01, offsets 4..6 read 0x00, and `intrq` is low.
- R2: A write to command-block offsets 2..6 stores the low byte of `wdata`. A read of that offset returns the byte with the upper 8 bits zero.
- R3: Bit 4 of the drive/head byte (offset 6) picks the device, and this block answers only when the bit equals `DEV_ID`. An unselected device reads 0x0000 on every offset and ignores command and data writes.
- R4: The media address is {drive/head[3:0], offset 5, offset 4, offset 3}, giving bits 27..0. It appears on `media_lba` with `media_nsect` sectors per block (1 by default). Each later block advances the address by the sectors already moved.
- R5: A command write (offset 7) from an idle, selected device reads 0x80 (busy) from the next cycle. While busy, writes to offsets 1..7 are ignored, and only device-control writes take effect.
- R6: PIO-in (opcode 0x20) sets status 0x58 and a pending interrupt when `media_done` arrives. A 16-bit data read returns `buf_rdata` and a byte read returns {0x00, `buf_rdata[7:0]`}, with `buf_addr` advancing by 2 or 1. After the last byte of a non-final block the status reads 0x80 and the next block is requested. After the final block the status reads 0x50 with no new interrupt.
- R7: PIO-out (opcode 0x30) reads 0x58 without an interrupt two cycles after the command. A full block of data writes gives status 0x80 and raises `media_req` with `media_wr` high. `media_done` then sets a pending interrupt and status 0x58, or 0x50 after the final block.
- R8: DMA opcodes 0xC8 (to host, `dma_rd`=1) and 0xCA (`dma_rd`=0) raise `dma_req` with status 0x88. `dma_done` gives 0x50, and `dma_abort` gives 0x70 with error byte (offset 1) 0x04. Both set a pending interrupt.
- R9: Any other opcode is non-data. It completes on the second clock after the command write, with status 0x50 and a pending interrupt.
- R10: `intrq` is the pending interrupt gated by device-control bit 1 (1 = masked). A status read (offset 7) clears the pending interrupt, and an alternate-status read (control offset 2) does not.
- R11: Device-control bit 2 set gives status 0x80, drops any command in flight and clears the pending interrupt, even while busy. Clearing the bit then returns status 0x50, sector count and sector number to 0x01, and offsets 4..6 to 0x00.
- R12: When a status read and an event that sets the interrupt fall in the same cycle, the interrupt stays pending.
- R13: Identify (opcode 0xEC) moves exactly one sector to the host, whatever the sector count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_cmd | input | 1 | Command-block select |
| cs_ctl | input | 1 | Control-block select |
| addr | input | 3 | Register offset |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wide | input | 1 | 16-bit access (data register) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational |
| intrq | output | 1 | Interrupt request |
| media_req | output | 1 | Media fill/commit request |
| media_wr | output | 1 | Request is a commit to media |
| media_lba | output | 28 | Block address of the request |
| media_nsect | output | 8 | Sectors in the current block |
| media_done | input | 1 | Media request finished (pulse) |
| buf_addr | output | AW | Byte offset in the sector buffer |
| buf_rd | output | 1 | Buffer read strobe |
| buf_wr | output | 1 | Buffer write strobe |
| buf_wide | output | 1 | Buffer access is 16-bit |
| buf_wdata | output | 16 | Buffer write data |
| buf_rdata | input | 16 | Buffer read data |
| dma_req | output | 1 | DMA transfer in progress |
| dma_rd | output | 1 | DMA direction, 1 = to host |
| dma_done | input | 1 | DMA finished (pulse) |
| dma_abort | input | 1 | DMA aborted (pulse) |

## Verification
The collision of interest is a host status read landing in the same cycle that the device sets its pending interrupt. The read clears the flag and the event sets it. The bench provokes this by driving the status read and `media_done` on the same edge while a PIO-in command waits for its first block. It expects the read to return busy (0x80) and `intrq` to be high afterwards. A second status read must then return 0x58 and lower `intrq`. Randomized register values, block addresses and byte/word access mixes surround this case.

// File: rtl/ata_taskfile_dev.sv
module ata_taskfile_dev #(
  parameter int DEV_ID     = 0,
  parameter int SECT_BYTES = 512,
  parameter int MULT_SECT  = 1,
  localparam int BLK       = (MULT_SECT < 1) ? 1 : ((MULT_SECT > 128) ? 128 : MULT_SECT),
  localparam int BLK_BYTES = BLK * SECT_BYTES,
  localparam int AW        = $clog2(BLK_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_cmd,
  input  logic          cs_ctl,
  input  logic [2:0]    addr,
  input  logic          rd,
  input  logic          wr,
  input  logic          wide,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  output logic          intrq,
  output logic          media_req,
  output logic          media_wr,
  output logic [27:0]   media_lba,
  output logic [7:0]    media_nsect,
  input  logic          media_done,
  output logic [AW-1:0] buf_addr,
  output logic          buf_rd,
  output logic          buf_wr,
  output logic          buf_wide,
  output logic [15:0]   buf_wdata,
  input  logic [15:0]   buf_rdata,
  output logic          dma_req,
  output logic          dma_rd,
  input  logic          dma_done,
  input  logic          dma_abort
);
  localparam logic [7:0] OP_RD_PIO = 8'h20, OP_WR_PIO = 8'h30, OP_RD_DMA = 8'hC8,
                         OP_WR_DMA = 8'hCA, OP_IDENT  = 8'hEC;
  localparam logic [7:0] ST_READY = 8'h50, ST_BUSY = 8'h80, ST_DRQ = 8'h58,
                         ST_DMA   = 8'h88, ST_FAULT = 8'h70;

  typedef enum logic [3:0] {
    S_IDLE, S_SRST, S_EXEC, S_PIN_PREP, S_PIN_XFER,
    S_POUT_XFER, S_POUT_COMMIT, S_DMA
  } state_t;

  state_t      state;
  logic [7:0]  nsect, sectn, cyl_lo, cyl_hi, dh, err, stat, cmd, blk_n;
  logic        nien, pend;
  logic [8:0]  sect_left, rem;
  logic [27:0] lba_cur;
  logic [AW-1:0] boff;
  logic [AW:0] blk_bytes, boff_sum;

  wire sel     = (dh[4] == DEV_ID[0]);
  wire bsy     = stat[7];
  wire tf_wr   = cs_cmd & wr & ~bsy;
  wire go      = cs_cmd & wr & (addr == 3'd7) & sel & ~bsy & (state == S_IDLE);
  wire ctl_wr  = cs_ctl & wr & (addr == 3'd2);
  wire st_rd   = cs_cmd & rd & (addr == 3'd7) & sel;
  wire dat_rd  = cs_cmd & rd & (addr == 3'd0) & sel & (state == S_PIN_XFER);
  wire dat_wr  = cs_cmd & wr & (addr == 3'd0) & sel & (state == S_POUT_XFER);
  wire blk_end = boff_sum >= blk_bytes;
  wire last    = (sect_left == {1'b0, blk_n});

  assign blk_bytes = (AW+1)'(blk_n) * (AW+1)'(SECT_BYTES);
  assign boff_sum  = {1'b0, boff} + (wide ? (AW+1)'(2) : (AW+1)'(1));
  assign rem       = sect_left - {1'b0, blk_n};

  function automatic logic [7:0] blk_of(input logic [8:0] n);
    return (n > 9'(BLK)) ? 8'(BLK) : n[7:0];
  endfunction

  assign intrq       = pend & ~nien;
  assign media_req   = (state == S_PIN_PREP) | (state == S_POUT_COMMIT);
  assign media_wr    = (state == S_POUT_COMMIT);
  assign media_lba   = lba_cur;
  assign media_nsect = blk_n;
  assign buf_addr    = boff;
  assign buf_rd      = dat_rd;
  assign buf_wr      = dat_wr;
  assign buf_wide    = wide;
  assign buf_wdata   = wdata;
  assign dma_req     = (state == S_DMA);
  assign dma_rd      = (cmd == OP_RD_DMA);

  always_comb begin
    rdata = 16'h0000;
    if (cs_cmd & rd & sel) begin
      case (addr)
        3'd0: rdata = (state != S_PIN_XFER) ? 16'h0000 :
                      (wide ? buf_rdata : {8'h00, buf_rdata[7:0]});
        3'd1: rdata = {8'h00, err};
        3'd2: rdata = {8'h00, nsect};
        3'd3: rdata = {8'h00, sectn};
        3'd4: rdata = {8'h00, cyl_lo};
        3'd5: rdata = {8'h00, cyl_hi};
        3'd6: rdata = {8'h00, dh};
        default: rdata = {8'h00, stat};
      endcase
    end else if (cs_ctl & rd & sel & (addr == 3'd2)) begin
      rdata = {8'h00, stat};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  stat <= ST_READY; err <= 8'h00; cmd <= 8'h00;
      nsect <= 8'h01;   sectn <= 8'h01;   cyl_lo <= 8'h00; cyl_hi <= 8'h00; dh <= 8'h00;
      nien <= 1'b0;     pend <= 1'b0;     sect_left <= '0; blk_n <= 8'h00;
      lba_cur <= '0;    boff <= '0;
    end else begin
      if (tf_wr) begin
        case (addr)
          3'd2: nsect  <= wdata[7:0];
          3'd3: sectn  <= wdata[7:0];
          3'd4: cyl_lo <= wdata[7:0];
          3'd5: cyl_hi <= wdata[7:0];
          3'd6: dh     <= wdata[7:0];
          default: ;
        endcase
      end
      if (st_rd) pend <= 1'b0;
      if (ctl_wr) nien <= wdata[1];

      case (state)
        S_IDLE: if (go) begin
          cmd <= wdata[7:0]; stat <= ST_BUSY; err <= 8'h00; pend <= 1'b0;
          lba_cur <= {dh[3:0], cyl_hi, cyl_lo, sectn};
          sect_left <= (nsect == 8'h00) ? 9'd256 : {1'b0, nsect};
          state <= S_EXEC;
        end
        S_EXEC: begin
          boff <= '0;
          case (cmd)
            OP_RD_PIO: begin blk_n <= blk_of(sect_left); state <= S_PIN_PREP; end
            OP_IDENT:  begin blk_n <= 8'h01; sect_left <= 9'd1; state <= S_PIN_PREP; end
            OP_WR_PIO: begin blk_n <= blk_of(sect_left); stat <= ST_DRQ; state <= S_POUT_XFER; end
            OP_RD_DMA, OP_WR_DMA: begin stat <= ST_DMA; state <= S_DMA; end
            default:   begin stat <= ST_READY; pend <= 1'b1; state <= S_IDLE; end
          endcase
        end
        S_PIN_PREP: if (media_done) begin
          stat <= ST_DRQ; pend <= 1'b1; boff <= '0; state <= S_PIN_XFER;
        end
        S_PIN_XFER: if (dat_rd) begin
          if (blk_end) begin
            boff <= '0; sect_left <= rem; lba_cur <= lba_cur + 28'(blk_n);
            if (last) begin stat <= ST_READY; state <= S_IDLE; end
            else begin stat <= ST_BUSY; blk_n <= blk_of(rem); state <= S_PIN_PREP; end
          end else boff <= boff_sum[AW-1:0];
        end
        S_POUT_XFER: if (dat_wr) begin
          if (blk_end) begin boff <= '0; stat <= ST_BUSY; state <= S_POUT_COMMIT; end
          else boff <= boff_sum[AW-1:0];
        end
        S_POUT_COMMIT: if (media_done) begin
          sect_left <= rem; lba_cur <= lba_cur + 28'(blk_n); pend <= 1'b1;
          if (last) begin stat <= ST_READY; state <= S_IDLE; end
          else begin stat <= ST_DRQ; blk_n <= blk_of(rem); state <= S_POUT_XFER; end
        end
        S_DMA: begin
          if (dma_abort) begin
            stat <= ST_FAULT; err <= 8'h04; pend <= 1'b1; state <= S_IDLE;
          end else if (dma_done) begin
            stat <= ST_READY; pend <= 1'b1; state <= S_IDLE;
          end
        end
        default: ;
      endcase

      if (ctl_wr) begin
        if (wdata[2]) begin
          state <= S_SRST; stat <= ST_BUSY; pend <= 1'b0;
        end else if (state == S_SRST) begin
          state <= S_IDLE; stat <= ST_READY; err <= 8'h00;
          nsect <= 8'h01; sectn <= 8'h01; cyl_lo <= 8'h00; cyl_hi <= 8'h00; dh <= 8'h00;
        end
      end
    end
  end
endmodule

// File: rtl/ata_taskfile_dev_chk.sv
module ata_taskfile_dev_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_cmd,
  input logic       cs_ctl,
  input logic [2:0] addr,
  input logic       rd,
  input logic       wr,
  input logic [15:0] wdata,
  input logic       media_req,
  input logic       dma_req,
  input logic       dma_done,
  input logic       dma_abort,
  input logic [7:0] stat,
  input logic [3:0] st,
  input logic       pend,
  input logic       sel
);
  wire ctl_w = cs_ctl & wr;

  p_media_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    media_req |-> stat[7]);

  p_cmd_bsy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_cmd && wr && addr == 3'd7 && sel && st == 4'd0) |=> stat[7]);

  p_rd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd0 && cs_cmd && rd && !wr && addr == 3'd7 && sel) |=> !pend);

  p_dma_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd7 && dma_done && !dma_abort && !ctl_w) |=> (stat == 8'h50 && pend));

  p_dma_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd7 && dma_abort && !ctl_w) |=> (stat == 8'h70 && pend));

  p_dma_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (stat == 8'h88));

  p_srst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && addr == 3'd2 && wdata[2]) |=> (stat == 8'h80 && !pend && !media_req));

  p_drq_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat[3] |-> (st == 4'd4 || st == 4'd5 || st == 4'd7));
endmodule

bind ata_taskfile_dev ata_taskfile_dev_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_cmd(cs_cmd), .cs_ctl(cs_ctl), .addr(addr),
  .rd(rd), .wr(wr), .wdata(wdata), .media_req(media_req), .dma_req(dma_req),
  .dma_done(dma_done), .dma_abort(dma_abort), .stat(stat), .st(state),
  .pend(pend), .sel(sel)
);

// File: tb/ata_taskfile_dev_tb.sv
`timescale 1ns/1ps
module ata_taskfile_dev_tb;
  localparam int AW = 9;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_cmd = 0, cs_ctl = 0, rd = 0, wr = 0, wide = 0;
  logic [2:0] addr = 0;
  logic [15:0] wdata = 0, rdata, buf_wdata, buf_rdata;
  logic intrq, media_req, media_wr, media_done = 0, buf_rd, buf_wr, buf_wide;
  logic dma_req, dma_rd, dma_done = 0, dma_abort = 0;
  logic [27:0] media_lba;
  logic [7:0] media_nsect;
  logic [AW-1:0] buf_addr;
  int nchk = 0, nfail = 0;
  logic [15:0] q;
  logic [AW-1:0] cap_baddr;

  always #2.5 clk = ~clk;

  ata_taskfile_dev u_dut (
    .clk(clk), .rst_n(rst_n), .cs_cmd(cs_cmd), .cs_ctl(cs_ctl), .addr(addr),
    .rd(rd), .wr(wr), .wide(wide), .wdata(wdata), .rdata(rdata), .intrq(intrq),
    .media_req(media_req), .media_wr(media_wr), .media_lba(media_lba),
    .media_nsect(media_nsect), .media_done(media_done), .buf_addr(buf_addr),
    .buf_rd(buf_rd), .buf_wr(buf_wr), .buf_wide(buf_wide), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .dma_req(dma_req), .dma_rd(dma_rd),
    .dma_done(dma_done), .dma_abort(dma_abort)
  );

  function automatic logic [7:0] bfun(input int a);
    return 8'(a * 37 + 11);
  endfunction
  assign buf_rdata = {bfun(int'(buf_addr) + 1), bfun(int'(buf_addr))};

  function automatic logic [27:0] exp_lba(input logic [7:0] h, ch, cl, s);
    return {h[3:0], ch, cl, s};
  endfunction

  task automatic chk(input string tag, input longint got, input longint exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic acc(input bit ctl, input bit [2:0] a, input bit w, input bit wd,
                     input logic [15:0] d, output logic [15:0] r);
    @(negedge clk);
    cs_cmd = !ctl; cs_ctl = ctl; addr = a; wr = w; rd = !w; wide = wd; wdata = d;
    #1 r = rdata; cap_baddr = buf_addr;
    @(posedge clk); #1;
    cs_cmd = 0; cs_ctl = 0; rd = 0; wr = 0; wide = 0;
  endtask

  task automatic wreg(input bit [2:0] a, input logic [7:0] d);
    logic [15:0] t; acc(0, a, 1, 0, {8'h00, d}, t);
  endtask
  task automatic rreg(input bit [2:0] a, output logic [15:0] r);
    acc(0, a, 0, 0, 16'h0, r);
  endtask
  task automatic wctl(input logic [7:0] d);
    logic [15:0] t; acc(1, 3'd2, 1, 0, {8'h00, d}, t);
  endtask
  task automatic ralt(output logic [15:0] r);
    acc(1, 3'd2, 0, 0, 16'h0, r);
  endtask
  task automatic idle1;
    @(posedge clk); #1;
  endtask

  task automatic media_ack(input logic [27:0] lba, input bit mw, input bit with_rd, input string tag);
    int n = 0;
    @(negedge clk);
    while (!media_req && n < 40) begin @(negedge clk); n++; end
    chk({tag, " media_req"}, media_req, 1);
    chk({tag, " lba R4"}, media_lba, lba);
    chk({tag, " media_wr"}, media_wr, mw);
    chk({tag, " nsect R4"}, media_nsect, 1);
    media_done = 1;
    if (with_rd) begin cs_cmd = 1; rd = 1; addr = 3'd7; end
    #1 q = rdata;
    @(posedge clk); #1;
    media_done = 0; cs_cmd = 0; rd = 0;
  endtask

  task automatic read_block(input string tag);
    int off = 0;
    while (off < 512) begin
      bit wd = (512 - off >= 2) && ($urandom % 2 == 1);
      logic [15:0] e = wd ? {bfun(off + 1), bfun(off)} : {8'h00, bfun(off)};
      acc(0, 3'd0, 0, wd, 16'h0, q);
      chk({tag, " data R6"}, q, e);
      chk({tag, " buf_addr R6"}, cap_baddr, off);
      off += wd ? 2 : 1;
    end
  endtask

  task automatic write_block(input string tag);
    for (int off = 0; off < 512; off += 2) begin
      acc(0, 3'd0, 1, 1, 16'($urandom), q);
      if (off % 64 == 0) chk({tag, " buf_addr R7"}, cap_baddr, off);
    end
  endtask

  task automatic set_lba(input logic [7:0] h, ch, cl, s, n);
    wreg(3'd3, s); wreg(3'd4, cl); wreg(3'd5, ch); wreg(3'd6, 8'h40 | {4'h0, h[3:0]}); wreg(3'd2, n);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    idle1;

    chk("R1 intrq", intrq, 0);
    rreg(3'd7, q); chk("R1 status", q, 16'h0050);
    rreg(3'd2, q); chk("R1 count", q, 16'h0001);
    rreg(3'd3, q); chk("R1 sector", q, 16'h0001);
    for (int a = 4; a <= 6; a++) begin rreg(3'(a), q); chk("R1 tf zero", q, 0); end

    for (int i = 0; i < 24; i++) begin
      bit [2:0] a = 3'(2 + $urandom % 5);
      logic [7:0] d = 8'($urandom);
      if (a == 3'd6) d[4] = 1'b0;
      wreg(a, d); rreg(a, q); chk("R2 readback", q, {8'h00, d});
    end

    wreg(3'd6, 8'h10);
    rreg(3'd7, q); chk("R3 unselected status", q, 0);
    rreg(3'd2, q); chk("R3 unselected count", q, 0);
    wreg(3'd7, 8'h00); idle1; idle1;
    wreg(3'd6, 8'h00);
    ralt(q); chk("R3 ignored cmd status", q, 16'h0050);
    chk("R3 ignored cmd intrq", intrq, 0);

    wreg(3'd7, 8'h91);
    ralt(q); chk("R5 busy after cmd", q, 16'h0080);
    chk("R9 intrq set", intrq, 1);
    ralt(q); chk("R9 complete", q, 16'h0050);
    chk("R10 alt keeps intr", intrq, 1);
    rreg(3'd7, q); chk("R10 status read", q, 16'h0050);
    chk("R10 status clears", intrq, 0);
    wctl(8'h02);
    wreg(3'd7, 8'h00); idle1; idle1;
    chk("R10 masked", intrq, 0);
    wctl(8'h00);
    chk("R10 unmask", intrq, 1);
    rreg(3'd7, q); chk("R10 clear", intrq, 0);

    begin
      logic [7:0] h = 8'($urandom), ch = 8'($urandom), cl = 8'($urandom), s = 8'($urandom);
      logic [27:0] l = exp_lba(h, ch, cl, s);
      set_lba(h, ch, cl, s, 8'd2);
      wreg(3'd7, 8'h20);
      wreg(3'd2, 8'h33);
      media_ack(l, 0, 1, "R12 pin blk0");
      chk("R12 read saw busy", q, 16'h0080);
      chk("R12 intr kept", intrq, 1);
      rreg(3'd7, q); chk("R6 drq", q, 16'h0058);
      chk("R6 intr cleared", intrq, 0);
      read_block("pin0");
      ralt(q); chk("R6 busy between blocks", q, 16'h0080);
      media_ack(l + 28'd1, 0, 0, "R6 pin blk1");
      rreg(3'd7, q); chk("R6 drq blk1", q, 16'h0058);
      read_block("pin1");
      rreg(3'd7, q); chk("R6 final status", q, 16'h0050);
      chk("R6 no final intr", intrq, 0);
      rreg(3'd2, q); chk("R5 write during busy ignored", q, 16'h0002);
    end

    begin
      logic [7:0] h = 8'($urandom), ch = 8'($urandom), cl = 8'($urandom), s = 8'($urandom);
      logic [27:0] l = exp_lba(h, ch, cl, s);
      set_lba(h, ch, cl, s, 8'd2);
      wreg(3'd7, 8'h30); idle1;
      ralt(q); chk("R7 drq no intr status", q, 16'h0058);
      chk("R7 no intr", intrq, 0);
      write_block("pout0");
      ralt(q); chk("R7 busy commit", q, 16'h0080);
      media_ack(l, 1, 0, "R7 pout blk0");
      chk("R7 intr blk0", intrq, 1);
      rreg(3'd7, q); chk("R7 drq blk1", q, 16'h0058);
      write_block("pout1");
      media_ack(l + 28'd1, 1, 0, "R7 pout blk1");
      chk("R7 intr final", intrq, 1);
      rreg(3'd7, q); chk("R7 final status", q, 16'h0050);
    end

    wreg(3'd7, 8'hC8); idle1;
    chk("R8 dma_req", dma_req, 1);
    chk("R8 dma_rd", dma_rd, 1);
    ralt(q); chk("R8 dma status", q, 16'h0088);
    @(negedge clk); dma_done = 1; @(posedge clk); #1 dma_done = 0;
    chk("R8 dma_req off", dma_req, 0);
    chk("R8 done intr", intrq, 1);
    rreg(3'd7, q); chk("R8 done status", q, 16'h0050);
    wreg(3'd7, 8'hCA); idle1;
    chk("R8 dma write dir", dma_rd, 0);
    @(negedge clk); dma_abort = 1; @(posedge clk); #1 dma_abort = 0;
    chk("R8 abort intr", intrq, 1);
    rreg(3'd7, q); chk("R8 abort status", q, 16'h0070);
    rreg(3'd1, q); chk("R8 abort error", q, 16'h0004);

    set_lba(8'h0, 8'h0, 8'h0, 8'h0, 8'd5);
    wreg(3'd7, 8'hEC);
    media_ack(28'h0, 0, 0, "R13 ident");
    rreg(3'd7, q); chk("R13 drq", q, 16'h0058);
    read_block("ident");
    rreg(3'd7, q); chk("R13 single sector", q, 16'h0050);
    chk("R13 no more media", media_req, 0);

    set_lba(8'h3, 8'h12, 8'h34, 8'h56, 8'd1);
    wreg(3'd7, 8'h20); idle1;
    wctl(8'h04);
    ralt(q); chk("R11 srst busy", q, 16'h0080);
    chk("R11 media dropped", media_req, 0);
    wctl(8'h00);
    rreg(3'd7, q); chk("R11 srst done", q, 16'h0050);
    rreg(3'd2, q); chk("R11 count", q, 16'h0001);
    rreg(3'd3, q); chk("R11 sector", q, 16'h0001);
    rreg(3'd5, q); chk("R11 cyl high", q, 0);
    rreg(3'd6, q); chk("R11 drive head", q, 0);
    chk("R11 intr", intrq, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #1000000;
    nchk++; nfail++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule